// File: doc/BRIEF.md
# Measurement Cycle Run/Hold Sequencer

This block paces a converter's measurement cycles. Each cycle has a fixed length, set by a parameter, and that length is 40,002 clocks by default. While a cycle runs, the block shows a cycle-active flag and a running tick count, so that phase logic elsewhere can decode its own windows from that count. On the last tick of a cycle it gives a one-clock done pulse. The output scanner uses this pulse to begin its digit sequence.

A single asynchronous run/hold input controls the block. If the input is still high when a cycle ends, the next cycle starts at once. If the input is low at that point, the block stops and holds the final count. While the block is holding, a rising edge on the input starts exactly one new cycle. A rising edge that arrives during a cycle is ignored and is not stored for later. The input passes through a two-flop synchroniser, and a registered copy of its output is used to detect the rising edge.

Top module: `meas_cycle_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with run_hold_i low, busy_o is 0, done_o is 0 and count_o is 0.
- R2: An active cycle lasts exactly CYCLE_LEN clocks. During it, busy_o is 1 and count_o steps by one per clock from 0 up to CYCLE_LEN-1.
- R3: done_o is high for exactly one clock per cycle, in the clock where count_o equals CYCLE_LEN-1 with busy_o high. It is never high at any other time.
- R4: If the synchronised run/hold level is high at the final count, the next clock shows busy_o 1 and count_o 0, with no idle clock between the two cycles.
- R5: If the synchronised level is low at the final count, the cycle still completes. busy_o then drops, and count_o holds CYCLE_LEN-1.
- R6: While holding, a rising edge on run_hold_i starts one cycle. After the input rises, the third rising clock edge loads count_o 0 with busy_o 1.
- R7: A rising edge on run_hold_i that is synchronised while a cycle is active is ignored. Once the cycle ends, no restart follows from it.
- R8: The decision at the final count uses the input as it stood two clocks earlier. A drop seen at count CYCLE_LEN-3 ends in hold. A drop seen at count CYCLE_LEN-2 still yields one more full cycle.
- R9: While holding with no rising edge, busy_o and count_o do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_hold_i | input | 1 | Run/hold request, asynchronous |
| busy_o | output | 1 | High while a measurement cycle runs |
| done_o | output | 1 | One-clock pulse on the final count of a cycle |
| count_o | output | $clog2(CYCLE_LEN) | Tick count within the current or last cycle |

## Verification
The bench uses a short cycle length. It drives three input patterns, and each one separates a different behaviour. A held-high level shows that cycles wrap back to back, and a level dropped at set counts locates the synchroniser boundary where the cycle either stops or runs once more. A one-clock pulse, swept over every count of a running cycle, separates three cases: pulses that are ignored, pulses still visible at the final count as a high level, and pulses that land after completion and start a fresh cycle after one or two hold clocks.

// File: rtl/meas_cycle_pkg.sv
package meas_cycle_pkg;
  typedef enum logic [0:0] {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rh_sync.sv
module rh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rh_rise_detect.sv
module rh_rise_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int CYCLE_LEN = 40002,
  localparam int CNT_W = $clog2(CYCLE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign at_last_o = (cnt_q == LAST);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import meas_cycle_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic at_last_i,
  output logic clear_o,
  output logic inc_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    clear_o = 1'b0;
    inc_o   = 1'b0;
    unique case (state_q)
      ST_HOLD: begin
        if (rise_i) begin
          state_d = ST_RUN;
          clear_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (at_last_i) begin
          if (lvl_i) clear_o = 1'b1;   // back-to-back cycle
          else       state_d = ST_HOLD; // freeze final count
        end else begin
          inc_o = 1'b1;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == ST_RUN);
endmodule

// File: rtl/meas_cycle_seq.sv
module meas_cycle_seq #(
  parameter int CYCLE_LEN   = 40002,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(CYCLE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_hold_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic lvl_w, rise_w, clear_w, inc_w, at_last_w, busy_w;

  rh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_hold_i),
    .q_o   (lvl_w)
  );

  rh_rise_detect u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_w),
    .rise_o(rise_w)
  );

  seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl_w),
    .rise_i   (rise_w),
    .at_last_i(at_last_w),
    .clear_o  (clear_w),
    .inc_o    (inc_w),
    .busy_o   (busy_w)
  );

  cycle_counter #(.CYCLE_LEN(CYCLE_LEN)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_w),
    .inc_i    (inc_w),
    .cnt_o    (count_o),
    .at_last_o(at_last_w)
  );

  assign busy_o = busy_w;
  assign done_o = busy_w & at_last_w;
endmodule

// File: rtl/meas_cycle_seq_chk.sv
module meas_cycle_seq_chk #(
  parameter int CYCLE_LEN = 40002,
  parameter int CNT_W     = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic [CNT_W-1:0] count_i,
  input logic             rise_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && count_i != LAST) |=> (busy_i && count_i == $past(count_i) + 1'b1));

  p_count_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= LAST);

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ((busy_i && count_i == '0) || (!busy_i && count_i == LAST)));

  p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && rise_i) |=> (busy_i && count_i == '0));

  p_no_early_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> busy_i);

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !rise_i) |=> (!busy_i && $stable(count_i)));
endmodule

bind meas_cycle_seq meas_cycle_seq_chk #(
  .CYCLE_LEN(CYCLE_LEN),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_o),
  .done_i (done_o),
  .count_i(count_o),
  .rise_i (rise_w)
);

// File: tb/meas_cycle_seq_bench.sv
`timescale 1ns/1ps
module meas_cycle_seq_bench;
  localparam int L  = 12;
  localparam int CW = $clog2(L);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rh = 1'b0;
  logic          busy, done;
  logic [CW-1:0] cnt;
  int            n_chk = 0;
  int            n_err = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  meas_cycle_seq #(.CYCLE_LEN(L)) u_meas_cycle_seq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .run_hold_i(rh),
    .busy_o    (busy),
    .done_o    (done),
    .count_o   (cnt)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // at a negedge showing count k0 of an active cycle; ends at the negedge after the final count
  task automatic expect_run(int k0, int inj, int drop_at, string tag);
    for (int k = k0; k < L; k++) begin
      chk(tag, "busy", int'(busy), 1);
      chk("R2", "count", int'(cnt), k);
      chk("R3", "done", int'(done), (k == L-1) ? 1 : 0);
      if (k == inj) rh = 1'b1;
      else if (inj >= 0 && k == inj + 1) rh = 1'b0;
      if (k == drop_at) rh = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic expect_hold(int n, string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, "hold busy", int'(busy), 0);
      chk(tag, "hold count", int'(cnt), L-1);
      chk("R3", "hold done", int'(done), 0);
      @(negedge clk);
    end
  endtask

  // one-clock pulse from a negedge; returns at the negedge where count 0 should show
  task automatic pulse();
    rh = 1'b1;
    @(negedge clk);
    rh = 1'b0;
    @(negedge clk);
    chk("R6", "not yet started", int'(busy), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "count in reset", int'(cnt), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R9", "count after reset", int'(cnt), 0);
      chk("R1", "done after reset", int'(done), 0);
    end

    // single shot
    pulse();
    expect_run(0, -1, -1, "R6");
    expect_hold(5, "R5");

    // free running, three wraps, then drop mid-cycle
    rh = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6", "latency", int'(busy), 0);
    @(negedge clk);
    expect_run(0, -1, -1, "R2");
    expect_run(0, -1, -1, "R4");
    expect_run(0, -1, -1, "R4");
    expect_run(0, -1, L/2, "R5");
    expect_hold(4, "R5");

    // drop at L-3: holds
    rh = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    expect_run(0, -1, L-3, "R8");
    expect_hold(3, "R8");

    // drop at L-2: one more cycle
    rh = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    expect_run(0, -1, L-2, "R8");
    expect_run(0, -1, -1, "R8");
    expect_hold(3, "R8");

    // pulse swept across every count of a running cycle
    for (int off = 0; off < L; off++) begin
      pulse();
      expect_run(0, off, -1, "R7");
      rh = 1'b0;
      if (off <= L-4) begin
        expect_hold(4, "R7");
      end else if (off == L-3) begin
        expect_run(0, -1, -1, "R4");
        expect_hold(3, "R5");
      end else if (off == L-2) begin
        expect_hold(1, "R6");
        expect_run(0, -1, -1, "R6");
        expect_hold(3, "R5");
      end else begin
        expect_hold(2, "R6");
        expect_run(0, -1, -1, "R6");
        expect_hold(3, "R5");
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule